// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external 262144 x 8 asynchronous static RAM. The RAM has no clock, so every strobe edge has to respect a minimum time in nanoseconds. The controller accepts one single-word read or write at a time through a request/ready handshake. It then plays out the matching strobe sequence on the memory pins. For a read, it returns the captured byte together with a one-cycle valid pulse.

Each phase length is a whole number of clock cycles, computed when the design is built. The inputs are the clock period and the memory speed grade (45, 55 or 70 ns). Each interval is the required time divided by the period, rounded up, and never less than one cycle.

A write starts with a turnaround phase. In that phase the memory is selected, output enable is high and the data bus is not driven. Next comes the write-enable pulse, with the controller driving the data bus. The bus is held for one more cycle after write enable rises. A read holds output enable low for the access interval and samples the bus at the clock edge that ends that interval.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every cycle with `ready` high, the memory is in standby: `mem_sel_n`=1, `mem_sel_p`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0.
- R2: A request is taken only in a cycle where `req_valid` and `ready` are both high. `ready` is low in the following cycle and stays low while a transfer runs. While a transfer runs, changes on `req_addr` and `req_wdata` have no effect on `mem_addr`.
- R3: A write keeps `ready` low for N_TURN+N_PWE+1 cycles, and `mem_we_n` is low for exactly N_PWE of them. `mem_oe_n` stays high for the whole write. The data bus is driven from the falling edge of write enable until one cycle after it rises. With the default parameters (4 ns period, 45 ns grade), N_TURN=4 and N_PWE=9.
- R4: The write strobes meet the memory's minimums: a write-enable pulse of at least 35 ns, address and select valid at least 35 ns before the write ends, and data stable at least 20 ns before it ends.
- R5: A read keeps `mem_oe_n` low and `mem_we_n` high for N_ACC cycles (12 by default). `rd_valid` is a single-cycle pulse N_ACC+1 cycles after the accepting cycle, in the same cycle that `ready` returns.
- R6: `rd_data` during the `rd_valid` pulse equals the byte last written to that address.
- R7: The memory is selected (`mem_sel_n`=0 and `mem_sel_p`=1) only while a transfer runs. At least one standby cycle separates two transfers.
- R8: The controller never drives the data bus while `mem_oe_n` is low. It starts driving only after output enable has been high for at least 15 ns.
- R9: A request already waiting when a read completes is accepted in the same cycle that `rd_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller idle; request taken this cycle if valid |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| mem_addr | output | 18 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel_p | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_in | input | 8 | Data bus value seen at the pins |
| mem_dq_out | output | 8 | Data driven onto the bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
Read completion and acceptance of the next request can fall in the same cycle. In that cycle `rd_valid` pulses and `ready` returns high, so a host holding `req_valid` starts a new transfer at once. The bench provokes this by presenting a write request while a read is still in progress. In the cycle where `ready` returns, it requires `rd_valid` high, the expected read byte and both selects in standby. In the following cycle it requires `ready` low. The write is then read back to show it was not lost. A behavioural memory model flags any bus contention or strobe-timing violation across the whole overlap.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WEND   = 3'd3,
        ST_RACC   = 3'd4
    } asram_st_e;

    // cycles needed to cover ns at period per, at least one
    function automatic int cyc(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // access / cycle time equals the grade number
    function automatic int t_acc(input int g);
        return g;
    endfunction

    function automatic int t_oe_acc(input int g);
        if (g <= 45)      return 20;
        else if (g <= 55) return 25;
        else              return 35;
    endfunction

    function automatic int t_oe_hiz(input int g);
        if (g <= 45)      return 15;
        else if (g <= 55) return 20;
        else              return 25;
    endfunction

    function automatic int t_we_pulse(input int g);
        if (g <= 45)      return 35;
        else if (g <= 55) return 40;
        else              return 50;
    endfunction

    function automatic int t_data_setup(input int g);
        if (g <= 45)      return 20;
        else if (g <= 55) return 25;
        else              return 30;
    endfunction

    function automatic int t_sel_to_end(input int g);
        if (g <= 45)      return 35;
        else if (g <= 55) return 45;
        else              return 60;
    endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int AW     = 18,
    parameter int CW     = 4,
    parameter int N_TURN = 4,
    parameter int N_PWE  = 9,
    parameter int N_ACC  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic          cnt_last,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val,
    output logic          ready,
    output logic          accept,
    output logic          capture,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_sel_p,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_dq_oe
);

    typedef struct packed {
        asram_st_e     st;
        logic [AW-1:0] addr;
        logic          sel_n;
        logic          sel_p;
        logic          oe_n;
        logic          we_n;
        logic          dq_oe;
    } seq_s;

    localparam seq_s SEQ_RST = '{
        st: ST_IDLE, addr: '0, sel_n: 1'b1, sel_p: 1'b0,
        oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0
    };

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        capture  = 1'b0;
        accept   = (seq_q.st == ST_IDLE) && req_valid;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.addr = req_addr;
                    cnt_load   = 1'b1;
                    if (req_write) begin
                        seq_d.st = ST_WSETUP;
                        cnt_val  = CW'(N_TURN - 1);
                    end else begin
                        seq_d.st = ST_RACC;
                        cnt_val  = CW'(N_ACC - 1);
                    end
                end
            end
            ST_WSETUP: begin
                if (cnt_last) begin
                    seq_d.st = ST_WPULSE;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(N_PWE - 1);
                end
            end
            ST_WPULSE: begin
                if (cnt_last) seq_d.st = ST_WEND;
            end
            ST_WEND: begin
                seq_d.st = ST_IDLE;
            end
            ST_RACC: begin
                if (cnt_last) begin
                    capture  = 1'b1;
                    seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        // pins follow the state being entered, so they are registered
        seq_d.sel_n = (seq_d.st == ST_IDLE);
        seq_d.sel_p = (seq_d.st != ST_IDLE);
        seq_d.oe_n  = (seq_d.st != ST_RACC);
        seq_d.we_n  = (seq_d.st != ST_WPULSE);
        seq_d.dq_oe = (seq_d.st == ST_WPULSE) || (seq_d.st == ST_WEND);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign ready     = (seq_q.st == ST_IDLE);
    assign mem_addr  = seq_q.addr;
    assign mem_sel_n = seq_q.sel_n;
    assign mem_sel_p = seq_q.sel_p;
    assign mem_oe_n  = seq_q.oe_n;
    assign mem_we_n  = seq_q.we_n;
    assign mem_dq_oe = seq_q.dq_oe;

endmodule

// File: rtl/asram_dq.sv
module asram_dq #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] mem_dq_in,
    output logic [DW-1:0] mem_dq_out,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    typedef struct packed {
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } dq_s;

    dq_s dq_d, dq_q;

    always_comb begin
        dq_d        = dq_q;
        dq_d.rvalid = capture;
        if (accept)  dq_d.wdata = req_wdata;
        if (capture) dq_d.rdata = mem_dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dq_q <= '0;
        else        dq_q <= dq_d;
    end

    assign mem_dq_out = dq_q.wdata;
    assign rd_data    = dq_q.rdata;
    assign rd_valid   = dq_q.rvalid;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 4,
    parameter int SPEED_NS      = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel_p,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    localparam int P      = CLK_PERIOD_NS;
    localparam int N_TURN = cyc(t_oe_hiz(SPEED_NS), P);
    localparam int N_PWE  = imax(imax(cyc(t_we_pulse(SPEED_NS), P),
                                      cyc(t_data_setup(SPEED_NS), P)),
                                 imax(cyc(t_acc(SPEED_NS), P) - N_TURN - 1,
                                      cyc(t_sel_to_end(SPEED_NS), P) - N_TURN));
    localparam int N_ACC  = imax(cyc(t_acc(SPEED_NS), P),
                                 cyc(t_oe_acc(SPEED_NS), P));
    localparam int N_MAX  = imax(imax(N_TURN, N_PWE), N_ACC);
    localparam int CW     = $clog2(N_MAX + 1);

    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_last;
    logic          accept;
    logic          capture;

    asram_cnt #(.CW(CW)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    asram_seq #(
        .AW     (ADDR_W),
        .CW     (CW),
        .N_TURN (N_TURN),
        .N_PWE  (N_PWE),
        .N_ACC  (N_ACC)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .cnt_last  (cnt_last),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .ready     (ready),
        .accept    (accept),
        .capture   (capture),
        .mem_addr  (mem_addr),
        .mem_sel_n (mem_sel_n),
        .mem_sel_p (mem_sel_p),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_oe (mem_dq_oe)
    );

    asram_dq #(.DW(DATA_W)) dq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_wdata  (req_wdata),
        .capture    (capture),
        .mem_dq_in  (mem_dq_in),
        .mem_dq_out (mem_dq_out),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel_p,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_sel_n && !mem_sel_p && mem_oe_n && mem_we_n && !mem_dq_oe));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !$past(ready)) |-> $stable(mem_addr));

    assert_write_oe_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_write_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_sel_n && mem_sel_p));

    assert_drive_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> !mem_we_n);

    assert_drive_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    assert_drive_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> !mem_dq_oe);

    assert_rvalid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_rvalid_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ready);

    assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps

module asram_mem_model #(
    parameter int AW    = 18,
    parameter int DW    = 8,
    parameter int TAA   = 45,
    parameter int TDOE  = 20,
    parameter int THZOE = 15,
    parameter int TPWE  = 35,
    parameter int TSD   = 20,
    parameter int TSCS  = 35
) (
    input  logic [AW-1:0] addr,
    input  logic          sel_n,
    input  logic          sel_p,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [DW-1:0] din,
    input  logic          din_oe,
    output logic [DW-1:0] dout,
    output logic          lowz,
    output int            viol_wr,
    output int            viol_bus,
    output int            nwr
);
    logic [DW-1:0] mem [logic [AW-1:0]];
    logic sel, wr;
    assign sel = !sel_n && sel_p;
    assign wr  = sel && !we_n;

    realtime t_addr = 0, t_data = 0, t_sel = 0, t_wr = 0, t_wend = 0;
    realtime t_oef = 0, t_oer = 0, t_drv = 0;

    always @(addr)          t_addr = $realtime;
    always @(din, din_oe)   t_data = $realtime;
    always @(posedge sel)   t_sel  = $realtime;
    always @(posedge wr)    t_wr   = $realtime;
    always @(negedge wr)    t_wend = $realtime;
    always @(negedge oe_n)  t_oef  = $realtime;
    always @(posedge oe_n)  t_oer  = $realtime;
    always @(posedge din_oe) t_drv = $realtime;

    initial begin
        logic wr_prev, drv_prev;
        realtime now;
        viol_wr = 0; viol_bus = 0; nwr = 0;
        wr_prev = 1'b0; drv_prev = 1'b0;
        lowz = 1'b0; dout = 'x;
        #0.5;
        forever begin
            now = $realtime;
            if (wr_prev && !wr) begin
                if (t_wend - t_wr   < TPWE) viol_wr++;
                if (t_wend - t_addr < TSCS) viol_wr++;
                if (t_wend - t_sel  < TSCS) viol_wr++;
                if (t_wend - t_data < TSD)  viol_wr++;
                if (!din_oe)                viol_wr++;
                mem[addr] = din;
                nwr++;
            end
            if (!drv_prev && din_oe && (t_drv - t_oer < THZOE)) viol_bus++;
            lowz = sel && !oe_n && we_n;
            if (din_oe && lowz) viol_bus++;
            if (lowz && (now - t_addr >= TAA) && (now - t_sel >= TAA) &&
                (now - t_oef >= TDOE) && mem.exists(addr))
                dout = mem[addr];
            else
                dout = 'x;
            wr_prev  = wr;
            drv_prev = din_oe;
            #1;
        end
    end
endmodule

module asram_ctrl_tb_top;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int T  = 4;

    function automatic int cy(input int ns);
        int c;
        c = (ns + T - 1) / T;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_TURN = cy(15);
    localparam int E_PWE  = mx(mx(cy(35), cy(20)), mx(cy(45) - E_TURN - 1, cy(35) - E_TURN));
    localparam int E_ACC  = mx(cy(45), cy(20));

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic mem_sel_n, mem_sel_p, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_in, mem_dq_out, m_dout;
    logic m_lowz;
    int viol_wr, viol_bus, nwr;

    int checks = 0;
    int errors = 0;
    int exp_nwr = 0;
    bit done = 1'b0;

    always #(T/2) clk = ~clk;

    assign mem_dq_in = mem_dq_oe ? mem_dq_out : m_dout;

    asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(T), .SPEED_NS(45)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel_p(mem_sel_p), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe)
    );

    asram_mem_model #(.AW(AW), .DW(DW)) model_i (
        .addr(mem_addr), .sel_n(mem_sel_n), .sel_p(mem_sel_p), .oe_n(mem_oe_n),
        .we_n(mem_we_n), .din(mem_dq_out), .din_oe(mem_dq_oe), .dout(m_dout),
        .lowz(m_lowz), .viol_wr(viol_wr), .viol_bus(viol_bus), .nwr(nwr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // write with full strobe accounting (R3)
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int busy, we_lo, oe_lo, sel_bad;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(!ready, "R2 ready low after accept", ready, 0);
        busy = 0; we_lo = 0; oe_lo = 0; sel_bad = 0;
        while (!ready) begin
            busy++;
            if (!mem_we_n) we_lo++;
            if (!mem_oe_n) oe_lo++;
            if (mem_sel_n || !mem_sel_p) sel_bad++;
            @(negedge clk);
        end
        exp_nwr++;
        chk(busy == E_TURN + E_PWE + 1, "R3 write busy cycles", busy, E_TURN + E_PWE + 1);
        chk(we_lo == E_PWE, "R3 write enable low cycles", we_lo, E_PWE);
        chk(oe_lo == 0, "R3 output enable high during write", oe_lo, 0);
        chk(sel_bad == 0, "R7 selected throughout write", sel_bad, 0);
        chk(mem_sel_n && !mem_sel_p, "R7 standby after write", {mem_sel_n, mem_sel_p}, 2);
    endtask

    // read with latency accounting (R5, R6)
    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        int busy, oe_lo, we_lo;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0; oe_lo = 0; we_lo = 0;
        while (!ready) begin
            busy++;
            if (!mem_oe_n) oe_lo++;
            if (!mem_we_n) we_lo++;
            chk(!rd_valid, "R5 no valid while busy", rd_valid, 0);
            @(negedge clk);
        end
        chk(busy == E_ACC, "R5 read busy cycles", busy, E_ACC);
        chk(oe_lo == E_ACC && we_lo == 0, "R5 read strobes", oe_lo, E_ACC);
        chk(rd_valid, "R5 valid when ready returns", rd_valid, 1);
        chk(rd_data == exp, "R6 read data", rd_data, exp);
        @(negedge clk);
        chk(!rd_valid, "R5 valid is one cycle", rd_valid, 0);
    endtask

    task automatic t_reset();
        chk(ready, "R1 ready after reset", ready, 1);
        chk(mem_sel_n && !mem_sel_p, "R1 standby selects", {mem_sel_n, mem_sel_p}, 2);
        chk(mem_oe_n && mem_we_n, "R1 strobes high", {mem_oe_n, mem_we_n}, 3);
        chk(!mem_dq_oe && !rd_valid, "R1 no drive no valid", {mem_dq_oe, rd_valid}, 0);
    endtask

    task automatic t_basic();
        do_write(18'h00123, 8'hA5);
        do_read (18'h00123, 8'hA5);
        do_write(18'h3FFFF, 8'hFF);
        do_write(18'h00000, 8'h00);
        do_read (18'h3FFFF, 8'hFF);
        do_read (18'h00000, 8'h00);
        do_write(18'h00123, 8'h5A);
        do_read (18'h00123, 8'h5A);
    endtask

    task automatic t_random();
        logic [DW-1:0] vals [8];
        for (int i = 0; i < 8; i++) begin
            vals[i] = DW'($urandom);
            do_write(AW'((i + 3) * 32'h1357B), vals[i]);
        end
        for (int i = 7; i >= 0; i--) begin
            do_read(AW'((i + 3) * 32'h1357B), vals[i]);
        end
    endtask

    // host inputs toggle during a transfer with req_valid low (R2)
    task automatic t_ignore();
        int moved;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h2AAAA; req_wdata = 8'h3C;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        moved = 0;
        while (!ready) begin
            req_addr  = ~req_addr;
            req_wdata = ~req_wdata;
            if (mem_addr != 18'h2AAAA) moved++;
            @(negedge clk);
        end
        exp_nwr++;
        req_write = 1'b0;
        chk(moved == 0, "R2 address ignores host changes", moved, 0);
        do_read(18'h2AAAA, 8'h3C);
        do_read(18'h15555, 8'h00 | 8'h00);
    endtask

    // pending write accepted in the cycle the read completes (R9)
    task automatic t_b2b();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00123;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req_write = 1'b1; req_addr = 18'h01010; req_wdata = 8'hC3;
        while (!ready) @(negedge clk);
        chk(rd_valid, "R9 valid in accept cycle", rd_valid, 1);
        chk(rd_data == 8'h5A, "R9 read data at overlap", rd_data, 8'h5A);
        chk(mem_sel_n && !mem_sel_p, "R7 standby between transfers", {mem_sel_n, mem_sel_p}, 2);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(!ready, "R9 pending request accepted", ready, 0);
        while (!ready) @(negedge clk);
        exp_nwr++;
        do_read(18'h01010, 8'hC3);
    endtask

    task automatic t_model();
        chk(viol_wr == 0, "R4 write timing violations", viol_wr, 0);
        chk(viol_bus == 0, "R8 bus contention or turnaround", viol_bus, 0);
        chk(nwr == exp_nwr, "R3 writes seen by memory", nwr, exp_nwr);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_random();
        do_write(18'h15555, 8'h00);
        t_ignore();
        t_b2b();
        repeat (4) @(negedge clk);
        t_model();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * T);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            summary();
            $finish;
        end
    end

endmodule